// File: doc/BRIEF.md
# Folded AES-128 Encryption Core

This block turns one 128-bit plaintext block into its AES-128 ciphertext. It holds a single state register and one round of combinational logic, and it applies that logic to the register once per clock. Eleven round keys come in on a flat input bus from a separate key generator, which computes them beforehand. A one-cycle start strobe begins an encryption. The block reports busy while it works, then gives a single-cycle done pulse and leaves the result in an output register.

The core has sixteen byte substitution units. The key generator has none of its own. While the generator is active it drives a 32-bit word into the core and reads back the substituted word, and the first four units serve that request. In that window the core does not accept a start. It keeps no state that a decryptor needs, so a decryptor that uses the same round keys can run at the same time.

Top module: `aes_enc_core`

## Requirements
- R1: After reset, busy_o and done_o are 0 and ciphertext_o is all zeros.
- R2: A rising edge on which start_i=1, kx_active_i=0 and busy_o=0 accepts a request. busy_o is 1 from the next cycle on. plaintext_i is sampled only on that accepting edge, so later changes to it have no effect.
- R3: Count the accepting edge as edge 0. busy_o stays high through edges 1 to 9 and falls at edge 10. done_o is high for exactly the one cycle that follows edge 10.
- R4: When done_o is high, ciphertext_o holds the AES-128 encryption of the accepted plaintext. Round key k is taken from round_keys_i[128k+127:128k]. Key 0 is added first. Rounds 1 to 9 apply SubBytes, ShiftRows, MixColumns and AddRoundKey, and round 10 leaves out MixColumns. Byte 0 of a block is bits 127:120, and the bytes fill the state column by column.
- R5: A start_i pulse while kx_active_i=1 is ignored: busy_o stays 0 and ciphertext_o does not change.
- R6: A start_i pulse while busy_o=1 is ignored: the running result is unchanged and no second operation follows it.
- R7: While kx_active_i=1, each byte j (0 to 3) of kx_sub_out_o, at bits 31-8j down to 24-8j, is the AES S-box of the same byte of kx_sub_in_i, in the same cycle.
- R8: ciphertext_o changes only on the edge that raises done_o, and otherwise keeps its value.
- R9: A start request made during the done cycle is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to encrypt plaintext_i |
| kx_active_i | input | 1 | Key generator is running and is using the lent S-boxes |
| plaintext_i | input | 128 | Block to encrypt |
| round_keys_i | input | 1408 | Eleven round keys, key k at bits 128k+127:128k |
| kx_sub_in_i | input | 32 | Word the key generator wants substituted |
| busy_o | output | 1 | An encryption is in progress |
| done_o | output | 1 | One-cycle pulse when the ciphertext is ready |
| ciphertext_o | output | 128 | Result register |
| kx_sub_out_o | output | 32 | Substituted word for the key generator |

## Verification
The bench drives inputs and samples outputs on falling edges, so the accepting rising edge falls between two samples. On the first sample after the request the bench expects busy_o high. It expects done_o low and busy_o high on the next nine samples. On the eleventh sample it expects done_o high together with the ciphertext from its own reference model, and on the twelfth it expects done_o low with the ciphertext unchanged. The lent S-box path has no register, so the bench checks it on the same sample at which it drives the input.

// File: rtl/aes_enc_pkg.sv
// Package aes_enc_pkg
// Holds the shared sizes and the GF(2^8) arithmetic used by the datapath.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1 (0x11B).
package aes_enc_pkg;
    localparam int BLK_W   = 128;
    localparam int NBYTES  = BLK_W / 8;
    localparam int ROUNDS  = 10;
    localparam int NKEYS   = ROUNDS + 1;
    localparam int RK_W    = NKEYS * BLK_W;
    localparam int RND_W   = $clog2(ROUNDS + 1);

    typedef logic [7:0] byte_t;

    // Multiply by x in the field.
    function automatic byte_t gf_x2(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // General product of two field elements, shift and add.
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254, square and multiply; maps 0 to 0.
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r;
        r = 8'h01;
        for (int i = 7; i >= 0; i--) begin
            r = gf_mul(r, r);
            if (i != 0) r = gf_mul(r, a);
        end
        return r;
    endfunction
endpackage

// File: rtl/aes_enc_sbox.sv
// Module aes_enc_sbox
// One byte substitution unit: field inverse followed by the affine map.
// Purely combinational, with no table, so its area is only logic.
module aes_enc_sbox
    import aes_enc_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    byte_t inv_b;

    // Inverse, then XOR of four left rotations and the constant 0x63.
    always_comb begin
        inv_b = gf_inv(din);
        dout  = inv_b
              ^ {inv_b[6:0], inv_b[7]}
              ^ {inv_b[5:0], inv_b[7:6]}
              ^ {inv_b[4:0], inv_b[7:5]}
              ^ {inv_b[3:0], inv_b[7:4]}
              ^ 8'h63;
    end
endmodule

// File: rtl/aes_enc_round.sv
// Module aes_enc_round
// Completes one round after the S-boxes: ShiftRows, then MixColumns unless
// last_rnd is set, then the round key XOR. Byte i of a block sits at
// bits 127-8i..120-8i, with i = 4*column + row.
module aes_enc_round
    import aes_enc_pkg::*;
(
    input  logic [BLK_W-1:0] sub_state,
    input  logic [BLK_W-1:0] rkey,
    input  logic             last_rnd,
    output logic [BLK_W-1:0] rnd_out
);
    byte_t sb  [NBYTES];
    byte_t shr [NBYTES];
    byte_t mix [NBYTES];

    // Split the substituted block into bytes.
    always_comb begin
        for (int i = 0; i < NBYTES; i++) sb[i] = sub_state[BLK_W-1-8*i -: 8];
    end

    // Row r moves left by r columns.
    always_comb begin
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                shr[4*c + r] = sb[4*((c + r) % 4) + r];
    end

    // Column mix with the matrix rows 2 3 1 1 rotated; bypassed in the last round.
    always_comb begin
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                if (last_rnd) begin
                    mix[4*c + r] = shr[4*c + r];
                end else begin
                    mix[4*c + r] = gf_x2(shr[4*c + r])
                                 ^ gf_x2(shr[4*c + (r+1)%4]) ^ shr[4*c + (r+1)%4]
                                 ^ shr[4*c + (r+2)%4]
                                 ^ shr[4*c + (r+3)%4];
                end
            end
        end
    end

    // Round key addition and repacking.
    always_comb begin
        for (int i = 0; i < NBYTES; i++)
            rnd_out[BLK_W-1-8*i -: 8] = mix[i] ^ rkey[BLK_W-1-8*i -: 8];
    end
endmodule

// File: rtl/aes_enc_ctrl.sv
// Module aes_enc_ctrl
// Round sequencer. The round counter is the state: 0 is idle, 1..ROUNDS
// selects the round now being computed. It accepts a request only while
// idle and while the key generator is not using the lent S-boxes.
module aes_enc_ctrl
    import aes_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             kx_active_i,
    output logic             accept,
    output logic [RND_W-1:0] rnd_q,
    output logic             last_rnd,
    output logic             busy,
    output logic             done_q
);
    // Decode the request qualification and the round flags.
    always_comb begin
        busy     = (rnd_q != '0);
        accept   = start_i && !kx_active_i && !busy;
        last_rnd = (rnd_q == RND_W'(ROUNDS));
    end

    // Step the round counter and make the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                rnd_q <= RND_W'(1);
            end else if (busy) begin
                if (last_rnd) begin
                    rnd_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    rnd_q <= rnd_q + RND_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/aes_enc_core.sv
// Module aes_enc_core
// Folded AES-128 encryption: one state register, one round per clock.
// The first LEND S-boxes are shared with the key generator. It assumes
// kx_active_i is never raised while busy_o is high, and that round_keys_i
// is stable while busy_o is high.
module aes_enc_core
    import aes_enc_pkg::*;
#(
    parameter int LEND = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              kx_active_i,
    input  logic [BLK_W-1:0]  plaintext_i,
    input  logic [RK_W-1:0]   round_keys_i,
    input  logic [8*LEND-1:0] kx_sub_in_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [BLK_W-1:0]  ciphertext_o,
    output logic [8*LEND-1:0] kx_sub_out_o
);
    localparam int LW = 8 * LEND;

    logic             accept;
    logic [RND_W-1:0] rnd_q;
    logic             last_rnd;
    logic [BLK_W-1:0] state_q;
    logic [BLK_W-1:0] sbox_in;
    logic [BLK_W-1:0] sbox_out;
    logic [BLK_W-1:0] rkey;
    logic [BLK_W-1:0] rnd_out;

    aes_enc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .kx_active_i (kx_active_i),
        .accept      (accept),
        .rnd_q       (rnd_q),
        .last_rnd    (last_rnd),
        .busy        (busy_o),
        .done_q      (done_o)
    );

    // Sixteen substitution units; the lent ones take the key generator word when it asks.
    for (genvar g = 0; g < NBYTES; g++) begin : g_sbox
        if (g < LEND) begin : g_lent
            // Input select for a shared unit.
            always_comb begin
                sbox_in[BLK_W-1-8*g -: 8] = kx_active_i ? kx_sub_in_i[LW-1-8*g -: 8]
                                                        : state_q[BLK_W-1-8*g -: 8];
            end
            assign kx_sub_out_o[LW-1-8*g -: 8] = sbox_out[BLK_W-1-8*g -: 8];
        end else begin : g_own
            assign sbox_in[BLK_W-1-8*g -: 8] = state_q[BLK_W-1-8*g -: 8];
        end
        aes_enc_sbox u_sbox (
            .din  (sbox_in[BLK_W-1-8*g -: 8]),
            .dout (sbox_out[BLK_W-1-8*g -: 8])
        );
    end

    // Pick the key for the current round; key 0 is used at the accepting edge.
    always_comb begin
        rkey = round_keys_i[rnd_q*BLK_W +: BLK_W];
    end

    aes_enc_round u_round (
        .sub_state (sbox_out),
        .rkey      (rkey),
        .last_rnd  (last_rnd),
        .rnd_out   (rnd_out)
    );

    // State register: whitening at acceptance, then one round per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (accept) begin
            state_q <= plaintext_i ^ round_keys_i[BLK_W-1:0];
        end else if (busy_o) begin
            state_q <= rnd_out;
        end
    end

    // Result register, written only by the last round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ciphertext_o <= '0;
        end else if (busy_o && last_rnd) begin
            ciphertext_o <= rnd_out;
        end
    end
endmodule

// File: rtl/aes_enc_core_chk.sv
// Module aes_enc_core_chk
// Protocol checker for aes_enc_core, bound to every instance below.
// A counter measures how long each busy stretch lasts.
module aes_enc_core_chk
    import aes_enc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             kx_active_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [BLK_W-1:0] ciphertext_o
);
    logic [RND_W:0] run_len;

    // Count consecutive busy cycles; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= '0;
        else if (busy_o) run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end

    // R2: a qualified request makes the core busy on the next cycle.
    assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !kx_active_i && !busy_o) |=> busy_o);

    // R3: done follows exactly ROUNDS busy cycles and lasts one cycle.
    assert_done_after_rounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_len == (RND_W+1)'(ROUNDS)));
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R5: no start while the key generator owns the shared units.
    assert_keygen_blocks_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kx_active_i && !busy_o) |=> !busy_o);

    // R8: the result only moves together with the done pulse.
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ciphertext_o));
endmodule

bind aes_enc_core aes_enc_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .kx_active_i  (kx_active_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .ciphertext_o (ciphertext_o)
);

// File: tb/aes_enc_core_tb_top.sv
module aes_enc_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NR   = 10;
    localparam int RKW  = 128 * (NR + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic           kx_active_i = 1'b0;
    logic [127:0]   plaintext_i = '0;
    logic [RKW-1:0] round_keys_i = '0;
    logic [31:0]    kx_sub_in_i = '0;
    logic           busy_o;
    logic           done_o;
    logic [127:0]   ciphertext_o;
    logic [31:0]    kx_sub_out_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [7:0] sbt [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_enc_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .kx_active_i  (kx_active_i),
        .plaintext_i  (plaintext_i),
        .round_keys_i (round_keys_i),
        .kx_sub_in_i  (kx_sub_in_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .ciphertext_o (ciphertext_o),
        .kx_sub_out_o (kx_sub_out_o)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] xt(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // S-box table built by walking the field with generator 3 and its inverse.
    task automatic build_sbox();
        logic [7:0] p, q, x;
        p = 8'h01; q = 8'h01;
        for (int n = 0; n < 255; n++) begin
            p = p ^ xt(p);
            q = q ^ {q[6:0], 1'b0};
            q = q ^ {q[5:0], 2'b0};
            q = q ^ {q[3:0], 4'b0};
            if (q[7]) q = q ^ 8'h09;
            x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]} ^ 8'h63;
            sbt[p] = x;
        end
        sbt[0] = 8'h63;
    endtask

    function automatic logic [RKW-1:0] expand(input logic [127:0] key);
        logic [31:0] w [44];
        logic [31:0] t;
        logic [7:0]  rc;
        logic [RKW-1:0] r;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {sbt[t[23:16]], sbt[t[15:8]], sbt[t[7:0]], sbt[t[31:24]]} ^ {rc, 24'h0};
                rc = xt(rc);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int k = 0; k < 11; k++)
            r[128*k +: 128] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
        return r;
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [RKW-1:0] rk);
        logic [7:0] s [16];
        logic [7:0] t [16];
        logic [127:0] o;
        for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ rk[127-8*i -: 8];
        for (int rn = 1; rn <= 10; rn++) begin
            for (int i = 0; i < 16; i++) t[i] = sbt[s[(i + 4*(i%4)) % 16]];
            for (int c = 0; c < 4; c++) begin
                logic [7:0] a0, a1, a2, a3;
                a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
                if (rn != 10) begin
                    t[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
                    t[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
                    t[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
                    t[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
                end
            end
            for (int i = 0; i < 16; i++) s[i] = t[i] ^ rk[128*rn + 127 - 8*i -: 8];
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
        return o;
    endfunction

    // Full encryption with cycle checks; optional ignored request at sample 5.
    task automatic run_enc(input logic [127:0] pt, input logic [RKW-1:0] rk,
                           input bit poke_busy, input string tag);
        logic [127:0] exp;
        exp = ref_enc(pt, rk);
        @(negedge clk);
        plaintext_i = pt; round_keys_i = rk; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        plaintext_i = ~pt;
        check(busy_o === 1'b1, "R2 busy after accept", {127'd0, busy_o}, 128'd1);
        for (int k = 2; k <= 10; k++) begin
            if (poke_busy && k == 5) begin
                start_i = 1'b1; plaintext_i = pt ^ 128'h1;
            end
            @(negedge clk);
            start_i = 1'b0;
            check(done_o === 1'b0 && busy_o === 1'b1, "R3 busy window",
                  {126'd0, done_o, busy_o}, 128'd1);
        end
        @(negedge clk);
        check(done_o === 1'b1 && busy_o === 1'b0, "R3 done on time",
              {126'd0, done_o, busy_o}, 128'd2);
        check(ciphertext_o === exp, {"R4 ", tag}, ciphertext_o, exp);
        @(negedge clk);
        check(done_o === 1'b0, "R3 done single cycle", {127'd0, done_o}, 128'd0);
        check(ciphertext_o === exp, "R8 result held", ciphertext_o, exp);
        if (poke_busy)
            check(busy_o === 1'b0, "R6 no queued operation", {127'd0, busy_o}, 128'd0);
    endtask

    initial begin
        logic [RKW-1:0] rk;
        logic [127:0] hold, a, b;
        void'($urandom(32'd20240517));
        build_sbox();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags after reset",
              {126'd0, busy_o, done_o}, 128'd0);
        check(ciphertext_o === 128'd0, "R1 result after reset", ciphertext_o, 128'd0);

        // Known answer vector.
        rk = expand(128'h5468617473206d79204b756e67204675);
        check(ref_enc(128'h54776f204f6e65204e696e652054776f, rk) === 128'h29c3505f571420f6402299b31a02d73a,
              "R4 bench model", ref_enc(128'h54776f204f6e65204e696e652054776f, rk),
              128'h29c3505f571420f6402299b31a02d73a);
        run_enc(128'h54776f204f6e65204e696e652054776f, rk, 1'b0, "known answer");

        // Directed patterns and random blocks.
        run_enc(128'h0, rk, 1'b0, "all zero");
        run_enc({128{1'b1}}, expand({128{1'b1}}), 1'b0, "all one");
        for (int n = 0; n < 24; n++) begin
            if (n % 4 == 0) rk = expand({$urandom, $urandom, $urandom, $urandom});
            run_enc({$urandom, $urandom, $urandom, $urandom}, rk, 1'b0, "random block");
        end

        // R7: lent S-boxes answer the key generator combinationally.
        kx_active_i = 1'b1;
        for (int n = 0; n < 8; n++) begin
            logic [31:0] wv, ev;
            wv = $urandom;
            if (n == 0) wv = 32'h00_53_FF_01;
            kx_sub_in_i = wv;
            #1;
            ev = {sbt[wv[31:24]], sbt[wv[23:16]], sbt[wv[15:8]], sbt[wv[7:0]]};
            check(kx_sub_out_o === ev, "R7 lent substitution", {96'd0, kx_sub_out_o}, {96'd0, ev});
            @(negedge clk);
        end

        // R5: request during key generation is dropped.
        hold = ciphertext_o;
        start_i = 1'b1; plaintext_i = 128'h1234;
        @(negedge clk);
        start_i = 1'b0;
        for (int n = 0; n < 3; n++) begin
            check(busy_o === 1'b0, "R5 start blocked", {127'd0, busy_o}, 128'd0);
            @(negedge clk);
        end
        check(ciphertext_o === hold, "R5 result untouched", ciphertext_o, hold);
        kx_active_i = 1'b0;

        // R6: request while busy is dropped.
        run_enc(128'hdeadbeef_00112233_44556677_8899aabb, rk, 1'b1, "R6 run");

        // R9: back-to-back request in the done cycle.
        a = {$urandom, $urandom, $urandom, $urandom};
        b = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        plaintext_i = a; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        check(done_o === 1'b1 && ciphertext_o === ref_enc(a, rk), "R9 first result",
              ciphertext_o, ref_enc(a, rk));
        plaintext_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R9 accepted in done cycle", {127'd0, busy_o}, 128'd1);
        repeat (10) @(negedge clk);
        check(done_o === 1'b1 && ciphertext_o === ref_enc(b, rk), "R9 second result",
              ciphertext_o, ref_enc(b, rk));

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule